// File: doc/BRIEF.md
# Bit-Span Modify Unit

This execution unit rewrites a contiguous run of bits inside a 32-bit register value in a single operation. A 10-bit operand names the lowest bit of the run and how many further bits follow it. A 3-bit operation code chooses what is written into every bit of the run. The choices are a constant zero or one, the carry flag or its inverse, the zero flag or its inverse, the matching bits of a random word, or the inverse of the bits already there. Bits outside the run pass through unchanged. A run that goes past the top bit continues from bit 0.

A prefix instruction can supply the run length in place of the operand's length field. The prefix is presented on its own strobe with a 5-bit value. It stays pending through idle cycles and is used by exactly one following operation, after which it is cleared. Results come out of a register one clock after the operation is presented, together with a valid strobe. Register file access and flag writeback belong to the surrounding pipeline.

Top module: `bit_span_unit`

## Requirements
- R1: `operand[4:0]` is the lowest bit of the run and `operand[9:5]` is the count of extra bits, so the run covers `operand[9:5]+1` bits starting at the base.
- R2: A run reaching past bit 31 continues at bit 0, bit 1 and upward, modulo 32.
- R3: Every result bit outside the run equals the corresponding bit of `dst`.
- R4: Op code 0 clears every run bit and op code 1 sets every run bit.
- R5: Op code 2 writes `c_in` into every run bit and op code 3 writes the inverse of `c_in`.
- R6: Op code 4 writes `z_in` into every run bit and op code 5 writes the inverse of `z_in`.
- R7: Op code 6 writes into each run bit the bit of `rnd_in` at the same position.
- R8: Op code 7 inverts every run bit of `dst`.
- R9: After a cycle with `pfx_valid` high, the next operation uses `pfx_len` in place of `operand[9:5]`, even across idle cycles. The operation after that one uses its own operand again.
- R10: A cycle with `op_valid` high gives `res_valid` high and the result on `res` one clock later. After reset, `res_valid` and `res` are 0.
- R11: When `pfx_valid` and `op_valid` are high in the same cycle, that operation uses whatever prefix was already pending, and the new prefix applies to the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation presented this cycle |
| op | input | 3 | Fill selection (0 clear … 7 invert) |
| dst | input | 32 | Value to modify |
| operand | input | 10 | Run base [4:0] and extra length [9:5] |
| c_in | input | 1 | Carry flag |
| z_in | input | 1 | Zero flag |
| rnd_in | input | 32 | Random word |
| pfx_valid | input | 1 | Length prefix presented this cycle |
| pfx_len | input | 5 | Prefix length value |
| res_valid | output | 1 | Result valid |
| res | output | 32 | Modified value |

## Verification
Each result is due on the clock edge that follows the cycle in which `op_valid` is seen. The bench drives inputs on falling edges, so a result appears on the next rising edge and is read one falling edge after it was driven. When an operation is issued, the driver pushes its expected value onto a queue. The monitor pops from that queue on every falling edge where `res_valid` is high, so any late, early, missing or extra result shows up as a mismatch or as a pop from an empty queue.

// File: rtl/bit_span_unit.sv
module bit_span_unit #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op,
  input  logic [W-1:0]    dst,
  input  logic [2*IW-1:0] operand,
  input  logic            c_in,
  input  logic            z_in,
  input  logic [W-1:0]    rnd_in,
  input  logic            pfx_valid,
  input  logic [IW-1:0]   pfx_len,
  output logic            res_valid,
  output logic [W-1:0]    res
);

  logic          pend;
  logic [IW-1:0] pend_len;
  logic [IW-1:0] base, len;
  logic [W-1:0]  span_mask, fill;

  assign base = operand[IW-1:0];
  assign len  = pend ? pend_len : operand[2*IW-1:IW];

  always_comb begin
    for (int i = 0; i < W; i++) begin
      logic [IW-1:0] off;
      off = IW'(i) - base;
      span_mask[i] = (off <= len);
    end
  end

  always_comb begin
    case (op)
      3'd0:    fill = '0;
      3'd1:    fill = '1;
      3'd2:    fill = {W{c_in}};
      3'd3:    fill = {W{~c_in}};
      3'd4:    fill = {W{z_in}};
      3'd5:    fill = {W{~z_in}};
      3'd6:    fill = rnd_in;
      default: fill = ~dst;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_len  <= '0;
      res_valid <= 1'b0;
      res       <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res <= (dst & ~span_mask) | (fill & span_mask);
      if (pfx_valid) begin
        pend     <= 1'b1;
        pend_len <= pfx_len;
      end else if (op_valid) begin
        pend <= 1'b0;
      end
    end
  end

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  assert_idle_no_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  assert_prefix_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_valid |=> pend);
  assert_prefix_consumed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !pfx_valid) |=> !pend);
  assert_outside_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ((res ^ $past(dst)) & ~$past(span_mask)) == '0);
  assert_clear_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == 3'd0) |=> (res & $past(span_mask)) == '0);

endmodule

// File: tb/bit_span_unit_tb_top.sv
module bit_span_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] dst = '0;
  logic [9:0]  operand = '0;
  logic        c_in = 1'b0, z_in = 1'b0;
  logic [31:0] rnd_in = '0;
  logic        pfx_valid = 1'b0;
  logic [4:0]  pfx_len = '0;
  logic        res_valid;
  logic [31:0] res;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        m_pend = 1'b0;
  logic [4:0]  m_len = '0;
  logic [31:0] lcg = 32'h1234_5678;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bit_span_unit dut_i (.clk, .rst_n, .op_valid, .op, .dst, .operand, .c_in, .z_in,
    .rnd_in, .pfx_valid, .pfx_len, .res_valid, .res);

  function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] d,
      input logic [4:0] b, input logic [4:0] l, input logic c, input logic z,
      input logic [31:0] r);
    logic [31:0] v = d;
    for (int k = 0; k <= 31; k++) begin
      if (k <= l) begin
        int p = (b + k) % 32;
        case (o)
          3'd0: v[p] = 1'b0;
          3'd1: v[p] = 1'b1;
          3'd2: v[p] = c;
          3'd3: v[p] = !c;
          3'd4: v[p] = z;
          3'd5: v[p] = !z;
          3'd6: v[p] = r[p];
          default: v[p] = !d[p];
        endcase
      end
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input string tag, input logic [2:0] o, input logic [31:0] d,
      input logic [9:0] opnd, input logic c, input logic z, input logic [31:0] r,
      input logic pv = 1'b0, input logic [4:0] pl = '0);
    logic [4:0] l = m_pend ? m_len : opnd[9:5];
    op_valid = 1'b1; op = o; dst = d; operand = opnd; c_in = c; z_in = z; rnd_in = r;
    pfx_valid = pv; pfx_len = pl;
    exp_q.push_back(model(o, d, opnd[4:0], l, c, z, r));
    tag_q.push_back(tag);
    if (pv) begin m_pend = 1'b1; m_len = pl; end else m_pend = 1'b0;
    @(negedge clk);
    op_valid = 1'b0; pfx_valid = 1'b0;
  endtask

  task automatic prefix(input logic [4:0] pl);
    pfx_valid = 1'b1; pfx_len = pl; m_pend = 1'b1; m_len = pl;
    @(negedge clk);
    pfx_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: actual unexpected result %h expected none", res);
      end else begin
        string t = tag_q.pop_front();
        check(t, res, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset valid", {31'b0, res_valid}, 32'h0);
    check("R10 reset res", res, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    issue("R4 clear single bit0", 3'd0, 32'hFFFF_FFFF, {5'd0, 5'd0}, 0, 0, 0);
    issue("R1 R4 set 8 bits at 4", 3'd1, 32'h0, {5'd7, 5'd4}, 0, 0, 0);
    issue("R2 wrap set", 3'd1, 32'h0, {5'd3, 5'd30}, 0, 0, 0);
    issue("R5 write C=1", 3'd2, 32'h0F0F_0F0F, {5'd11, 5'd8}, 1, 0, 0);
    issue("R5 write C=0", 3'd2, 32'hFFFF_FFFF, {5'd5, 5'd16}, 0, 1, 0);
    issue("R5 write notC", 3'd3, 32'h0, {5'd9, 5'd20}, 0, 0, 0);
    issue("R6 write Z", 3'd4, 32'h0, {5'd2, 5'd1}, 0, 1, 0);
    issue("R6 write notZ", 3'd5, 32'hFFFF_FFFF, {5'd4, 5'd29}, 1, 1, 0);
    issue("R7 random", 3'd6, 32'hAAAA_5555, {5'd15, 5'd10}, 0, 0, 32'h1357_9BDF);
    issue("R8 invert full", 3'd7, 32'hDEAD_BEEF, {5'd31, 5'd7}, 0, 0, 0);
    issue("R3 neighbours kept", 3'd0, 32'hFFFF_FFFF, {5'd1, 5'd15}, 0, 0, 0);
    @(negedge clk);
    prefix(5'd2);
    @(negedge clk);
    @(negedge clk);
    issue("R9 prefix length used", 3'd1, 32'h0, {5'd0, 5'd8}, 0, 0, 0);
    issue("R9 prefix cleared", 3'd1, 32'h0, {5'd0, 5'd8}, 0, 0, 0);
    prefix(5'd31);
    issue("R11 same cycle uses old", 3'd7, 32'h0, {5'd1, 5'd0}, 0, 0, 0, 1'b1, 5'd4);
    issue("R11 new prefix next", 3'd1, 32'h0, {5'd0, 5'd12}, 0, 0, 0);
    for (int n = 0; n < 60; n++) begin
      logic [31:0] a, b;
      lcg = lcg * 32'd1664525 + 32'd1013904223; a = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223; b = lcg;
      if (b[31:29] == 3'd0) prefix(b[4:0]);
      issue("R1 R3 mixed", a[2:0], b, a[12:3], a[13], a[14], a ^ b);
    end
    repeat (3) @(negedge clk);
    check("R10 queue drained", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule